// File: doc/BRIEF.md
# Synchronous Burst SRAM With Byte Writes

This block is a single-port synchronous SRAM with a built-in four-beat burst address sequencer. Address, data, chip selects, the address strobe, the advance input and the write controls are all sampled on the rising clock edge. An address strobe while the chip is selected starts an access at the supplied address. Each following cycle continues the access at the burst address. The advance input steps the two low address bits through an interleaved or linear four-beat order, picked by a parameter. A strobe while the chip is not selected ends the access.

Writes are either per byte lane (a byte-write enable combined with lane selects) or global (all lanes). A mode input selects between a flow-through read path and a pipelined read path with one extra output register. The output enable and the sleep input act without waiting for a clock. Sleep idles the outputs and freezes all state, and the stored words are kept. Words are 18, 32 or 36 bits wide. An 18-bit word has two lanes and the wider words have four.

Top module: `sbsram_core`

## Requirements
- R1: The chip is selected only when cs0_ni=0, cs1_i=1 and cs2_ni=0. A strobe (start_i=1) sampled while not selected ends any access in progress and writes nothing.
- R2: With pipe_mode_i=0 (flow-through), the data of a read sampled at edge k is on data_o with valid_o=1 from just after edge k until edge k+1.
- R3: With pipe_mode_i=1 (pipelined), the data of a read sampled at edge k appears one edge later, after edge k+1, and valid_o stays low between edge k and edge k+1 unless an earlier read is being delivered.
- R4: A selected strobe loads the base address and sets the beat count to 0. Each later cycle without a strobe continues the access. With adv_i=1 the count goes up by one (modulo 4). With adv_i=0 the same address is accessed again. The accessed address keeps the upper bits of the base. Its two low bits are base[1:0] XOR count when LINEAR_ORDER=0, and base[1:0] + count modulo 4 when LINEAR_ORDER=1.
- R5: A cycle is a byte write when bw_en_i=1 and lane_en_i is not zero. Only the lanes whose lane_en_i bit is set are written, and lane l is data bits [l*LANE_W +: LANE_W]. Lane selects without bw_en_i (and without gw_en_i) write nothing; the cycle is then a read.
- R6: With gw_en_i=1 an access cycle writes every lane, whatever the values of bw_en_i and lane_en_i.
- R7: data_oe_o and valid_o are high only while a read result is present, oe_i=1 and sleep_i=0. A change of oe_i takes effect without a clock edge. data_o is all zeros whenever data_oe_o is low. A write cycle produces no read result.
- R8: In flow-through mode a deselecting strobe idles the output from the very next cycle. In pipelined mode the output idles one cycle later.
- R9: While sleep_i=1 the outputs are idle at once, and no edge writes the array or changes the address, count or active state. Stored data survives, and the burst resumes where it stopped.
- R10: While rst_ni is low no access is active and the outputs are idle. After reset release, cycles without a strobe do not access the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Address sampled with a strobe |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| start_i | input | 1 | Address strobe: load address or deselect |
| adv_i | input | 1 | Step the burst count on a continuation cycle |
| data_i | input | WORD_W | Write data |
| lane_en_i | input | LANES | Per-lane write selects |
| bw_en_i | input | 1 | Byte-write enable |
| gw_en_i | input | 1 | Global write of all lanes |
| oe_i | input | 1 | Output enable, asynchronous |
| sleep_i | input | 1 | Sleep, asynchronous, freezes state |
| pipe_mode_i | input | 1 | 1 = pipelined read, 0 = flow-through read |
| data_o | output | WORD_W | Read data, zero when not driven |
| data_oe_o | output | 1 | Output driver enable, models high impedance when low |
| valid_o | output | 1 | Read data valid |

## Verification
The bench walks an interleaved burst through a wrap and a repeat beat. A sequencer with the wrong order or a count that is not taken modulo 4 returns words from the wrong addresses. It measures read latency in both modes, so a missing or doubled output register shows data one cycle off. It merges partial lane writes against a known word and tries lane selects without the byte-write enable. A decode that writes unselected lanes, or treats bare lane selects as a write, corrupts the readback. It goes to sleep in the middle of a burst with a write pending. A design that keeps counting, forgets the burst, or lets the write through returns the wrong next beat. It also toggles the output enable within a cycle to catch an output gate that waits for a clock edge.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic int lane_count(input int word_w);
    return (word_w == 18) ? 2 : 4;
  endfunction

endpackage

// File: rtl/sbsram_burst_seq.sv
`timescale 1ns/1ps
module sbsram_burst_seq #(
  parameter int ADDR_W       = 6,
  parameter bit LINEAR_ORDER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [1:0]        cnt_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [1:0]        low_bits;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      base_d = addr_i;
      cnt_d  = 2'd0;
    end else if (step_i) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // address of the access taken at this edge
  generate
    if (LINEAR_ORDER) begin : g_linear
      assign low_bits = base_d[1:0] + cnt_d;
    end else begin : g_interleave
      assign low_bits = base_d[1:0] ^ cnt_d;
    end
  endgenerate

  assign acc_addr_o = {base_d[ADDR_W-1:2], low_bits};
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int LANE_W = WORD_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_i[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/sbsram_rd_path.sv
`timescale 1ns/1ps
module sbsram_rd_path #(
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_i,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] data_o
);

  logic              vld_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_i;
      data_q <= data_i;
    end
  end

  assign vld_o  = pipe_i ? vld_q  : vld_i;
  assign data_o = pipe_i ? data_q : data_i;

endmodule

// File: rtl/sbsram_core.sv
`timescale 1ns/1ps
module sbsram_core #(
  parameter int     ADDR_W       = 6,
  parameter int     WORD_W       = 36,
  parameter bit     LINEAR_ORDER = 1'b0,
  localparam int    LANES        = sbsram_pkg::lane_count(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs0_ni,
  input  logic              cs1_i,
  input  logic              cs2_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic              bw_en_i,
  input  logic              gw_en_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  input  logic              pipe_mode_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              valid_o
);
  import sbsram_pkg::*;

  logic              sel, awake, wr_req;
  logic              load, drop, step, acc_go;
  logic              active_q;
  acc_e              acc;
  logic [ADDR_W-1:0] acc_addr, rd_addr_q;
  logic [1:0]        burst_cnt;
  logic [LANES-1:0]  mem_we;
  logic              rd_q;
  logic [WORD_W-1:0] arr_rdata, path_data;
  logic              path_vld, show;

  assign sel    = !cs0_ni && cs1_i && !cs2_ni;
  assign awake  = !sleep_i;
  assign wr_req = gw_en_i || (bw_en_i && |lane_en_i);
  assign load   = awake && start_i && sel;
  assign drop   = awake && start_i && !sel;
  assign step   = awake && !start_i && active_q && adv_i;
  assign acc_go = load || (awake && !start_i && active_q);

  always_comb begin
    if (!acc_go)     acc = ACC_NONE;
    else if (wr_req) acc = ACC_WRITE;
    else             acc = ACC_READ;
  end

  always_comb begin
    mem_we = '0;
    if (acc == ACC_WRITE) mem_we = gw_en_i ? {LANES{1'b1}} : lane_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (load)      active_q <= 1'b1;
      else if (drop) active_q <= 1'b0;
      rd_q <= (acc == ACC_READ);
      if (acc == ACC_READ) rd_addr_q <= acc_addr;
    end
  end

  sbsram_burst_seq #(
    .ADDR_W      (ADDR_W),
    .LINEAR_ORDER(LINEAR_ORDER)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .addr_i    (addr_i),
    .acc_addr_o(acc_addr),
    .cnt_o     (burst_cnt)
  );

  sbsram_array #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .LANES (LANES)
  ) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(acc_addr),
    .wdata_i(data_i),
    .raddr_i(rd_addr_q),
    .rdata_o(arr_rdata)
  );

  sbsram_rd_path #(
    .WORD_W(WORD_W)
  ) u_rd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pipe_i(pipe_mode_i),
    .vld_i (rd_q),
    .data_i(arr_rdata),
    .vld_o (path_vld),
    .data_o(path_data)
  );

  // output gate is combinational: oe and sleep need no clock
  assign show      = path_vld && oe_i && !sleep_i && rst_ni;
  assign data_oe_o = show;
  assign valid_o   = show;
  assign data_o    = show ? path_data : '0;

endmodule

// File: rtl/sbsram_core_chk.sv
`timescale 1ns/1ps
module sbsram_core_chk #(
  parameter int WORD_W = 36,
  parameter int LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oe_i,
  input logic              sleep_i,
  input logic              start_i,
  input logic              adv_i,
  input logic              gw_en_i,
  input logic              bw_en_i,
  input logic              pipe_mode_i,
  input logic              sel_i,
  input logic              active_i,
  input logic              acc_go_i,
  input logic [LANES-1:0]  mem_we_i,
  input logic [1:0]        cnt_i,
  input logic              valid_o,
  input logic              data_oe_o,
  input logic [WORD_W-1:0] data_o
);

  a_r1_unselected_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !sel_i) |-> (mem_we_i == '0));

  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !start_i && adv_i && !sleep_i) |=> (cnt_i == 2'($past(cnt_i) + 2'd1)));

  a_r4_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!start_i && !adv_i) || sleep_i) |=> $stable(cnt_i));

  a_r5_no_write_unless_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gw_en_i && !bw_en_i) |-> (mem_we_i == '0));

  a_r6_global_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_en_i && acc_go_i) |-> (&mem_we_i));

  a_r7_oe_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!data_oe_o && !valid_o));

  a_r7_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  a_r8_single_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !sel_i && !sleep_i && !pipe_mode_i) |=> (pipe_mode_i || !valid_o));

  a_r9_sleep_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!valid_o && !data_oe_o && (mem_we_i == '0)));

  a_r9_sleep_keeps_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(active_i));

endmodule

bind sbsram_core sbsram_core_chk #(
  .WORD_W(WORD_W),
  .LANES (LANES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oe_i       (oe_i),
  .sleep_i    (sleep_i),
  .start_i    (start_i),
  .adv_i      (adv_i),
  .gw_en_i    (gw_en_i),
  .bw_en_i    (bw_en_i),
  .pipe_mode_i(pipe_mode_i),
  .sel_i      (sel),
  .active_i   (active_q),
  .acc_go_i   (acc_go),
  .mem_we_i   (mem_we),
  .cnt_i      (burst_cnt),
  .valid_o    (valid_o),
  .data_oe_o  (data_oe_o),
  .data_o     (data_o)
);

// File: tb/sbsram_core_bench.sv
`timescale 1ns/1ps
module sbsram_core_bench;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 36;
  localparam int LANES  = 4;
  localparam int LANE_W = WORD_W / LANES;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              cs0_ni = 1'b0, cs1_i = 1'b1, cs2_ni = 1'b0;
  logic              start_i = 1'b0, adv_i = 1'b0;
  logic [WORD_W-1:0] data_i = '0;
  logic [LANES-1:0]  lane_en_i = '0;
  logic              bw_en_i = 1'b0, gw_en_i = 1'b0;
  logic              oe_i = 1'b1, sleep_i = 1'b0, pipe_mode_i = 1'b0;
  logic [WORD_W-1:0] data_o;
  logic              data_oe_o, valid_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  sbsram_core #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINEAR_ORDER(1'b0)) u_sbsram_core (
    .clk_i, .rst_ni, .addr_i, .cs0_ni, .cs1_i, .cs2_ni, .start_i, .adv_i,
    .data_i, .lane_en_i, .bw_en_i, .gw_en_i, .oe_i, .sleep_i, .pipe_mode_i,
    .data_o, .data_oe_o, .valid_o
  );

  function automatic logic [WORD_W-1:0] pat(input int a);
    return 36'h5_A5A5_A500 + WORD_W'(a);
  endfunction

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old_w,
      input logic [WORD_W-1:0] new_w, input logic [LANES-1:0] lanes);
    logic [WORD_W-1:0] r = old_w;
    for (int l = 0; l < LANES; l++)
      if (lanes[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic quiet();
    start_i = 1'b0; adv_i = 1'b0; gw_en_i = 1'b0; bw_en_i = 1'b0; lane_en_i = '0;
    cs0_ni = 1'b0; cs1_i = 1'b1; cs2_ni = 1'b0;
  endtask

  task automatic deselect();
    quiet(); start_i = 1'b1; cs0_ni = 1'b1;
    tick();
    quiet();
  endtask

  task automatic write_word(input int a, input logic [WORD_W-1:0] d);
    quiet(); start_i = 1'b1; addr_i = ADDR_W'(a); gw_en_i = 1'b1; data_i = d;
    tick();
    deselect();
  endtask

  task automatic read_flow(input int a, input logic [WORD_W-1:0] exp, input string req);
    pipe_mode_i = 1'b0;
    quiet(); start_i = 1'b1; addr_i = ADDR_W'(a);
    tick();
    chk(req, WORD_W'(valid_o), 1);
    chk(req, data_o, exp);
    deselect();
  endtask

  task automatic t_reset();
    chk("R10 valid in reset", WORD_W'(valid_o), 0);
    chk("R10 oe in reset", WORD_W'(data_oe_o), 0);
    rst_ni = 1'b1;
    tick(); tick();
    chk("R10 idle after reset", WORD_W'(valid_o), 0);
  endtask

  task automatic t_fill();
    for (int a = 4; a < 10; a++) write_word(a, pat(a));
    read_flow(4, pat(4), "R2 flow single read");
    chk("R8 flow idle after deselect", WORD_W'(valid_o), 0);
  endtask

  task automatic t_pipe();
    pipe_mode_i = 1'b1;
    quiet(); start_i = 1'b1; addr_i = 6'd4;
    tick();
    chk("R3 no data after first edge", WORD_W'(valid_o), 0);
    quiet(); adv_i = 1'b1;
    tick(); chk("R3 beat0", data_o, pat(4));
    tick(); chk("R3 beat1", data_o, pat(5));
    tick(); chk("R3 beat2", data_o, pat(6));
    deselect();
    chk("R3 beat3", data_o, pat(7));
    chk("R8 pipe still valid one cycle", WORD_W'(valid_o), 1);
    tick();
    chk("R8 pipe idle after two", WORD_W'(valid_o), 0);
    pipe_mode_i = 1'b0;
  endtask

  task automatic t_burst();
    pipe_mode_i = 1'b0;
    quiet(); start_i = 1'b1; addr_i = 6'd5;
    tick(); chk("R4 interleave beat0", data_o, pat(5));
    quiet(); adv_i = 1'b1;
    tick(); chk("R4 interleave beat1", data_o, pat(4));
    tick(); chk("R4 interleave beat2", data_o, pat(7));
    adv_i = 1'b0;
    tick(); chk("R4 hold repeats", data_o, pat(7));
    adv_i = 1'b1;
    tick(); chk("R4 interleave beat3", data_o, pat(6));
    tick(); chk("R4 wrap", data_o, pat(5));
    deselect();
    chk("R8 burst ended", WORD_W'(valid_o), 0);
  endtask

  task automatic t_lanes();
    logic [WORD_W-1:0] exp_w;
    logic [WORD_W-1:0] nw = 36'hF_0F0F_0F0F;
    exp_w = merge(pat(8), nw, 4'b0101);
    quiet(); start_i = 1'b1; addr_i = 6'd8; bw_en_i = 1'b1; lane_en_i = 4'b0101; data_i = nw;
    tick();
    chk("R7 write gives no result", WORD_W'(data_oe_o), 0);
    deselect();
    read_flow(8, exp_w, "R5 byte lanes merged");
    quiet(); start_i = 1'b1; addr_i = 6'd8; lane_en_i = 4'b1111; data_i = '0;
    tick();
    chk("R5 lanes without enable read", data_o, exp_w);
    deselect();
    read_flow(8, exp_w, "R5 lanes without enable kept");
    quiet(); start_i = 1'b1; addr_i = 6'd9; gw_en_i = 1'b1; bw_en_i = 1'b1; lane_en_i = 4'b0001;
    data_i = 36'h1_2345_6789;
    tick();
    deselect();
    read_flow(9, 36'h1_2345_6789, "R6 global write all lanes");
  endtask

  task automatic t_oe();
    quiet(); start_i = 1'b1; addr_i = 6'd4; oe_i = 1'b0;
    tick();
    chk("R7 oe low valid", WORD_W'(valid_o), 0);
    chk("R7 oe low bus", data_o, '0);
    oe_i = 1'b1;
    #1;
    chk("R7 oe async on", WORD_W'(data_oe_o), 1);
    chk("R7 oe async data", data_o, pat(4));
    deselect();
  endtask

  task automatic t_sleep();
    quiet(); start_i = 1'b1; addr_i = 6'd4;
    tick();
    quiet(); adv_i = 1'b1;
    tick(); chk("R9 pre-sleep beat", data_o, pat(5));
    sleep_i = 1'b1; gw_en_i = 1'b1; data_i = '0;
    #1; chk("R9 sleep idles at once", WORD_W'(valid_o), 0);
    tick(); tick();
    chk("R9 idle during sleep", WORD_W'(data_oe_o), 0);
    sleep_i = 1'b0; gw_en_i = 1'b0;
    tick();
    chk("R9 burst resumes, write blocked", data_o, pat(6));
    deselect();
  endtask

  task automatic t_select();
    quiet(); start_i = 1'b1; cs1_i = 1'b0; addr_i = 6'd4; gw_en_i = 1'b1; data_i = '0;
    tick();
    chk("R1 unselected no read", WORD_W'(valid_o), 0);
    quiet(); start_i = 1'b1; cs2_ni = 1'b1; addr_i = 6'd4; gw_en_i = 1'b1; data_i = '0;
    tick();
    quiet();
    read_flow(4, pat(4), "R1 unselected no write");
  endtask

  task automatic t_midreset();
    quiet(); start_i = 1'b1; addr_i = 6'd5;
    tick();
    rst_ni = 1'b0;
    #1; chk("R10 reset idles output", WORD_W'(valid_o), 0);
    tick(); rst_ni = 1'b1;
    quiet(); adv_i = 1'b1;
    tick();
    chk("R10 no access after reset", WORD_W'(valid_o), 0);
    quiet();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    t_fill();
    t_pipe();
    t_burst();
    t_lanes();
    t_oe();
    t_sleep();
    t_select();
    t_midreset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule